// File: doc/BRIEF.md
# Parallel Host Modem Port

This block is the host-facing side of a modem controller. A host processor reaches it through an 8-bit data bus with active-low chip select, read strobe and write strobe, plus one address line. The strobes are not tied to the block's clock. They pass through synchronizers, and each access takes effect when its strobe is released. Address 0 reaches the data path: a write queues one byte into a transmit FIFO, and a read takes one byte out of a receive FIFO. Address 1 reaches a control/status byte.

The status byte reports four things: a transmit low-water level, a receive-empty flag, an aggregated event flag, and two writable controls (an interrupt mask and a software escape request). Five sticky event flags are collected from the modem side: caller ID, overcurrent, parallel phone, ring and carrier detect. The modem side clears them with a dedicated strobe. A transmit low-water interrupt is raised when the transmit FIFO drains down to the threshold. The host acknowledges it by writing 0 to the low-water bit. The active-low interrupt pin combines both interrupt causes through the mask bit. The modem side drains the transmit FIFO and fills the receive FIFO through plain enable/data ports.

Top module: `par_host_port`

## Requirements
- R1: After reset the status byte reads 0x60, host_int_n is 1, host_doe is 0, esc_out is 0, tx_empty is 1 and rx_full is 0.
- R2: host_doe is 1 exactly while cs_n and rd_n are both 0. host_dout shows the status byte when addr is 1 and the receive FIFO head when addr is 0. The status byte layout is: bit 7 reads 0, bit 6 is the transmit low-water level, bit 5 is receive-empty, bit 4 is the interrupt mask, bit 3 is the event flag, bit 2 is the escape request, and bits 1:0 read 0.
- R3: A register write commits once, when wr_n rises while cs_n is low. It uses the address and data held during the strobe. A write strobe pulsed while cs_n is high changes nothing.
- R4: A data write (addr 0) appends one byte to the transmit FIFO, which holds TX_DEPTH (default 14) bytes. The modem side reads the bytes out in the order they were written. A data write to a full FIFO is dropped.
- R5: Status bit 6 reads 1 while the transmit FIFO holds TXE_LOW (default 2) or fewer bytes, and 0 otherwise.
- R6: A pending transmit interrupt is set when bit 6 goes from 0 to 1. A status write with bit 6 = 0 clears it. A status write with bit 6 = 1 leaves it unchanged. Neither kind of write changes the level reported in bit 6.
- R7: A data read (addr 0) removes the receive FIFO head when the read strobe ends. A data read from an empty receive FIFO returns 0x00 and removes nothing.
- R8: Status bit 5 reads 1 when the receive FIFO is empty and 0 when it holds data.
- R9: A 1 on evt_in[i] sets sticky flag evt_flags[i]. The bit order is: 4 caller ID, 3 overcurrent, 2 parallel phone, 1 ring, 0 carrier detect. evt_clr clears all flags. If a flag is set and cleared in the same cycle, it is set.
- R10: Status bit 3 is the OR of the five event flags.
- R11: host_int_n is 0 exactly when the mask bit (status bit 4) is 1 and either the event flag or the pending transmit interrupt is 1.
- R12: esc_out equals the escape request bit (status bit 2) AND hes_en.
- R13: Status writes ignore bits 7, 5, 3, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Host chip select, active low |
| rd_n | input | 1 | Host read strobe, active low |
| wr_n | input | 1 | Host write strobe, active low |
| addr | input | 1 | Host register select (0 data, 1 status) |
| host_din | input | 8 | Host write data |
| host_dout | output | 8 | Host read data |
| host_doe | output | 1 | Bus drive enable for host_dout |
| host_int_n | output | 1 | Interrupt pin, active low |
| tx_rd_en | input | 1 | Modem side takes one transmit byte |
| tx_rd_data | output | 8 | Transmit FIFO head |
| tx_empty | output | 1 | Transmit FIFO empty |
| rx_wr_en | input | 1 | Modem side stores one receive byte |
| rx_wr_data | input | 8 | Receive byte |
| rx_full | output | 1 | Receive FIFO full |
| evt_in | input | 5 | Event set pulses |
| evt_clr | input | 1 | Clear all event flags |
| hes_en | input | 1 | Hardware escape enable |
| evt_flags | output | 5 | Sticky event flags |
| esc_out | output | 1 | Gated escape request |

## Verification
The bench uses the default parameters: a 14-entry transmit FIFO, a 16-entry receive FIFO, a low-water threshold of 2 and two synchronizer stages. With 14 entries the transmit FIFO can be filled and overrun through slow strobed host writes in a few hundred cycles. The threshold of 2 lets the 2-to-3 and 3-to-2 level crossings occur within three writes. Two synchronizer stages fix the commit point at the third clock edge after a strobe is released, and each check samples after that edge.

// File: rtl/hp_pkg.sv
package hp_pkg;
  typedef logic [7:0] hbyte_t;
  localparam int NUM_EVT = 5;
  localparam int ST_TXE  = 6;
  localparam int ST_REM  = 5;
  localparam int ST_INTM = 4;
  localparam int ST_INT  = 3;
  localparam int ST_ESC  = 2;
endpackage

// File: rtl/hp_fifo.sv
module hp_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 14
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           push,
  input  logic [W-1:0]                   pdata,
  input  logic                           pop,
  output logic [W-1:0]                   head,
  output logic [$clog2(DEPTH+1)-1:0]     count
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          full, empty, do_push, do_pop;

  assign full    = (cnt_q == CW'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    cnt_d  = cnt_q;
    if (do_push) wptr_d = (wptr_q == LAST) ? '0 : wptr_q + PW'(1);
    if (do_pop)  rptr_d = (rptr_q == LAST) ? '0 : rptr_q + PW'(1);
    case ({do_push, do_pop})
      2'b10:   cnt_d = cnt_q + CW'(1);
      2'b01:   cnt_d = cnt_q - CW'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= pdata;
  end

  assign head  = mem[rptr_q];
  assign count = cnt_q;

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == CW'(DEPTH) && push && !pop) |=> (cnt_q == CW'(DEPTH))); // R4
  AST_EMPTY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '0 && pop && !push) |=> (cnt_q == '0)); // R7
endmodule

// File: rtl/hp_strobe.sv
module hp_strobe #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic       addr,
  input  logic [7:0] din,
  output logic       wr_commit,
  output logic       rd_done,
  output logic       cap_addr,
  output logic [7:0] cap_data
);
  logic [SYNC_STAGES:0] wr_sh, rd_sh;
  logic wr_act, rd_act, cap_en;
  logic       addr_q, addr_d;
  logic [7:0] data_q, data_d;

  assign wr_act = rd_n & ~cs_n & ~wr_n;
  assign rd_act = ~cs_n & ~rd_n;
  assign cap_en = wr_sh[SYNC_STAGES-1] | rd_sh[SYNC_STAGES-1];

  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    if (cap_en) begin
      addr_d = addr;
      data_d = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_sh  <= '0;
      rd_sh  <= '0;
      addr_q <= 1'b0;
      data_q <= '0;
    end else begin
      wr_sh  <= {wr_sh[SYNC_STAGES-1:0], wr_act};
      rd_sh  <= {rd_sh[SYNC_STAGES-1:0], rd_act};
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  assign wr_commit = wr_sh[SYNC_STAGES] & ~wr_sh[SYNC_STAGES-1];
  assign rd_done   = rd_sh[SYNC_STAGES] & ~rd_sh[SYNC_STAGES-1];
  assign cap_addr  = addr_q;
  assign cap_data  = data_q;

  AST_COMMIT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> !wr_commit); // R3
endmodule

// File: rtl/hp_status.sv
module hp_status
  import hp_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int TXE_LOW = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_stat,
  input  logic               wbit_txe,
  input  logic               wbit_intm,
  input  logic               wbit_esc,
  input  logic [CNT_W-1:0]   tx_count,
  input  logic               rx_empty,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               evt_clr,
  input  logic               hes_en,
  output hbyte_t             status,
  output logic [NUM_EVT-1:0] evt_flags,
  output logic               int_n,
  output logic               esc_out
);
  logic txe_lvl, txe_prev_q, txe_rise;
  logic pend_q, pend_d, intm_q, intm_d, esc_q, esc_d;
  logic [NUM_EVT-1:0] evt_q, evt_d;
  logic int_flag;

  assign txe_lvl  = (tx_count <= CNT_W'(TXE_LOW));
  assign txe_rise = txe_lvl & ~txe_prev_q;
  assign int_flag = |evt_q;

  always_comb begin
    pend_d = pend_q;
    intm_d = intm_q;
    esc_d  = esc_q;
    if (wr_stat) begin
      intm_d = wbit_intm;
      esc_d  = wbit_esc;
      if (!wbit_txe) pend_d = 1'b0;
    end
    if (txe_rise) pend_d = 1'b1;
    evt_d = (evt_clr ? '0 : evt_q) | evt_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txe_prev_q <= 1'b1;
      pend_q     <= 1'b0;
      intm_q     <= 1'b0;
      esc_q      <= 1'b0;
      evt_q      <= '0;
    end else begin
      txe_prev_q <= txe_lvl;
      pend_q     <= pend_d;
      intm_q     <= intm_d;
      esc_q      <= esc_d;
      evt_q      <= evt_d;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_TXE]  = txe_lvl;
    status[ST_REM]  = rx_empty;
    status[ST_INTM] = intm_q;
    status[ST_INT]  = int_flag;
    status[ST_ESC]  = esc_q;
  end

  assign evt_flags = evt_q;
  assign int_n     = ~(intm_q & (int_flag | pend_q));
  assign esc_out   = esc_q & hes_en;

  AST_TXE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && !wbit_txe && !txe_rise) |=> !pend_q); // R6
  AST_EVT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_clr |=> ((evt_q & $past(evt_q)) == $past(evt_q))); // R9
  AST_EVT_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_in != '0) |=> ((evt_q & $past(evt_in)) == $past(evt_in))); // R9
endmodule

// File: rtl/par_host_port.sv
module par_host_port
  import hp_pkg::*;
#(
  parameter int TX_DEPTH    = 14,
  parameter int RX_DEPTH    = 16,
  parameter int TXE_LOW     = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               rd_n,
  input  logic               wr_n,
  input  logic               addr,
  input  logic [7:0]         host_din,
  output logic [7:0]         host_dout,
  output logic               host_doe,
  output logic               host_int_n,
  input  logic               tx_rd_en,
  output logic [7:0]         tx_rd_data,
  output logic               tx_empty,
  input  logic               rx_wr_en,
  input  logic [7:0]         rx_wr_data,
  output logic               rx_full,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               evt_clr,
  input  logic               hes_en,
  output logic [NUM_EVT-1:0] evt_flags,
  output logic               esc_out
);
  localparam int TX_CW = $clog2(TX_DEPTH + 1);
  localparam int RX_CW = $clog2(RX_DEPTH + 1);

  logic       wr_commit, rd_done, cap_addr;
  hbyte_t     cap_data, rx_head, status;
  logic [TX_CW-1:0] tx_cnt;
  logic [RX_CW-1:0] rx_cnt;
  logic       rx_empty;

  hp_strobe #(.SYNC_STAGES(SYNC_STAGES)) u_strobe (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .din(host_din), .wr_commit(wr_commit), .rd_done(rd_done),
    .cap_addr(cap_addr), .cap_data(cap_data)
  );

  hp_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(wr_commit & ~cap_addr), .pdata(cap_data),
    .pop(tx_rd_en), .head(tx_rd_data), .count(tx_cnt)
  );

  hp_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_wr_en), .pdata(rx_wr_data),
    .pop(rd_done & ~cap_addr), .head(rx_head), .count(rx_cnt)
  );

  assign tx_empty = (tx_cnt == '0);
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == RX_CW'(RX_DEPTH));

  hp_status #(.CNT_W(TX_CW), .TXE_LOW(TXE_LOW)) u_stat (
    .clk(clk), .rst_n(rst_n), .wr_stat(wr_commit & cap_addr),
    .wbit_txe(cap_data[ST_TXE]), .wbit_intm(cap_data[ST_INTM]),
    .wbit_esc(cap_data[ST_ESC]), .tx_count(tx_cnt), .rx_empty(rx_empty),
    .evt_in(evt_in), .evt_clr(evt_clr), .hes_en(hes_en), .status(status),
    .evt_flags(evt_flags), .int_n(host_int_n), .esc_out(esc_out)
  );

  assign host_doe  = ~cs_n & ~rd_n;
  assign host_dout = addr ? status : (rx_empty ? 8'h00 : rx_head);

  AST_INT_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    !status[ST_INTM] |-> host_int_n); // R11
  AST_ESC_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !hes_en |-> !esc_out); // R12
  AST_TX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt <= TX_CW'(TX_DEPTH)); // R4
endmodule

// File: tb/par_host_port_test.sv
`timescale 1ns/1ps
module par_host_port_test;
  logic clk = 1'b0;
  logic rst_n;
  logic cs_n, rd_n, wr_n, addr;
  logic [7:0] host_din, host_dout, tx_rd_data, rx_wr_data;
  logic host_doe, host_int_n, tx_rd_en, tx_empty, rx_wr_en, rx_full;
  logic [4:0] evt_in, evt_flags;
  logic evt_clr, hes_en, esc_out;
  int nchk = 0;
  int nfail = 0;
  logic [7:0] got;
  logic oe;

  always #2 clk = ~clk;

  par_host_port uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .host_din(host_din), .host_dout(host_dout),
    .host_doe(host_doe), .host_int_n(host_int_n), .tx_rd_en(tx_rd_en),
    .tx_rd_data(tx_rd_data), .tx_empty(tx_empty), .rx_wr_en(rx_wr_en),
    .rx_wr_data(rx_wr_data), .rx_full(rx_full), .evt_in(evt_in),
    .evt_clr(evt_clr), .hes_en(hes_en), .evt_flags(evt_flags),
    .esc_out(esc_out)
  );

  // {write, addr, wdata, expected read}
  localparam logic [17:0] VEC [10] = '{
    {1'b0, 1'b1, 8'h00, 8'h60},
    {1'b1, 1'b0, 8'h11, 8'h00},
    {1'b1, 1'b0, 8'h22, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h60},
    {1'b1, 1'b0, 8'h33, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h20},
    {1'b1, 1'b1, 8'h14, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h34},
    {1'b1, 1'b1, 8'hCB, 8'h00},
    {1'b0, 1'b1, 8'h00, 8'h20}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_write(input logic a, input logic [7:0] d);
    @(negedge clk); cs_n = 1'b0; addr = a; host_din = d; wr_n = 1'b0;
    repeat (4) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic host_read(input logic a, output logic [7:0] d, output logic e);
    @(negedge clk); cs_n = 1'b0; addr = a; rd_n = 1'b0;
    repeat (2) @(negedge clk);
    d = host_dout; e = host_doe;
    repeat (2) @(negedge clk);
    rd_n = 1'b1;
    repeat (4) @(negedge clk);
    cs_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic tx_pop();
    @(negedge clk); tx_rd_en = 1'b1;
    @(negedge clk); tx_rd_en = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk); rx_wr_en = 1'b1; rx_wr_data = d;
    @(negedge clk); rx_wr_en = 1'b0;
  endtask

  task automatic evt_pulse(input logic [4:0] s, input logic c);
    @(negedge clk); evt_in = s; evt_clr = c;
    @(negedge clk); evt_in = '0; evt_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 1'b0;
    host_din = '0; tx_rd_en = 1'b0; rx_wr_en = 1'b0; rx_wr_data = '0;
    evt_in = '0; evt_clr = 1'b0; hes_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 int_n", {7'd0, host_int_n}, 8'h01);
    check("R1 doe", {7'd0, host_doe}, 8'h00);
    check("R1 esc_out", {7'd0, esc_out}, 8'h00);
    check("R1 tx_empty", {7'd0, tx_empty}, 8'h01);
    check("R1 rx_full", {7'd0, rx_full}, 8'h00);

    // Vector table: R1 R2 R3 R5 R13
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][17]) host_write(VEC[i][16], VEC[i][15:8]);
      else begin
        host_read(VEC[i][16], got, oe);
        check("R5/R13 status vector", got, VEC[i][7:0]);
        check("R2 doe during read", {7'd0, oe}, 8'h01);
      end
    end

    // R4 order out of transmit FIFO
    check("R4 head0", tx_rd_data, 8'h11); tx_pop();
    check("R4 head1", tx_rd_data, 8'h22); tx_pop();
    host_read(1'b1, got, oe);
    check("R5 level at 1 byte", got, 8'h60);
    check("R4 head2", tx_rd_data, 8'h33); tx_pop();
    check("R4 empty", {7'd0, tx_empty}, 8'h01);

    // R6 / R11 low-water interrupt
    check("R11 masked", {7'd0, host_int_n}, 8'h01);
    host_write(1'b1, 8'h50);
    check("R6 write1 keeps pending", {7'd0, host_int_n}, 8'h00);
    host_write(1'b1, 8'h10);
    check("R6 ack clears", {7'd0, host_int_n}, 8'h01);
    host_read(1'b1, got, oe);
    check("R6 level unchanged", got, 8'h70);

    // R4 overflow
    for (int i = 0; i < 15; i++) host_write(1'b0, 8'h40 + 8'(i));
    host_read(1'b1, got, oe);
    check("R5 level when full", got, 8'h30);
    for (int i = 0; i < 14; i++) begin
      check("R4 fill order", tx_rd_data, 8'h40 + 8'(i));
      tx_pop();
    end
    check("R4 overflow dropped", {7'd0, tx_empty}, 8'h01);
    host_write(1'b1, 8'h10);
    check("R6 ack after drain", {7'd0, host_int_n}, 8'h01);

    // R7 / R8 receive path
    rx_push(8'hA1); rx_push(8'hA2);
    host_read(1'b1, got, oe);
    check("R8 not empty", got, 8'h50);
    host_read(1'b0, got, oe);
    check("R7 first byte", got, 8'hA1);
    check("R2 doe data read", {7'd0, oe}, 8'h01);
    host_read(1'b0, got, oe);
    check("R7 second byte", got, 8'hA2);
    host_read(1'b1, got, oe);
    check("R8 empty again", got, 8'h70);
    host_read(1'b0, got, oe);
    check("R7 empty read", got, 8'h00);
    rx_push(8'hA3);
    host_read(1'b0, got, oe);
    check("R7 no underflow", got, 8'hA3);

    // R2 drive enable gating
    @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); check("R2 doe cs high", {7'd0, host_doe}, 8'h00);
    rd_n = 1'b1; cs_n = 1'b0;
    @(negedge clk); check("R2 doe rd high", {7'd0, host_doe}, 8'h00);
    cs_n = 1'b1;

    // R3 write without chip select ignored
    @(negedge clk); addr = 1'b1; host_din = 8'h00; wr_n = 1'b0;
    repeat (4) @(negedge clk); wr_n = 1'b1;
    repeat (6) @(negedge clk);
    host_read(1'b1, got, oe);
    check("R3 cs high write ignored", got, 8'h70);

    // R9 R10 R11 events
    evt_pulse(5'b00010, 1'b0);
    check("R9 ring flag", {3'd0, evt_flags}, 8'h02);
    check("R11 int asserted", {7'd0, host_int_n}, 8'h00);
    host_read(1'b1, got, oe);
    check("R10 int bit", got, 8'h78);
    evt_pulse(5'b10000, 1'b0);
    check("R9 sticky", {3'd0, evt_flags}, 8'h12);
    host_write(1'b1, 8'h00);
    check("R11 mask off", {7'd0, host_int_n}, 8'h01);
    host_read(1'b1, got, oe);
    check("R13 int bit not writable", got, 8'h68);
    evt_pulse(5'b00000, 1'b1);
    check("R9 clear", {3'd0, evt_flags}, 8'h00);
    host_read(1'b1, got, oe);
    check("R10 int cleared", got, 8'h60);
    evt_pulse(5'b00100, 1'b1);
    check("R9 set wins", {3'd0, evt_flags}, 8'h04);
    evt_pulse(5'b00000, 1'b1);

    // R12 escape gating
    host_write(1'b1, 8'h04);
    check("R12 esc gated", {7'd0, esc_out}, 8'h00);
    @(negedge clk); hes_en = 1'b1;
    @(negedge clk);
    check("R12 esc enabled", {7'd0, esc_out}, 8'h01);
    host_read(1'b1, got, oe);
    check("R12 esc bit", got, 8'h64);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule